// File: doc/BRIEF.md
# Run-Ahead Store Buffer with Youngest-Match Forwarding

This block holds a core's committed stores in a small circular queue and writes them to memory oldest first, one per accepted handshake on the drain port. While the core runs normally a lookup port lets a load see the youngest queued store to its address. When a store arrives and every slot is taken, the block does not hold up the pipeline. Instead it signals that the core should checkpoint and start running ahead. The core can also start that mode for its own reasons through a request input.

In run-ahead mode the block takes in speculative stores while free slots remain and forwards their data to later loads. Stores that arrive after the slots run out are thrown away without any warning. A load that aliases one of them reads whatever older data is present. Every run-ahead store whose address is known produces a one-cycle cache-line prefetch request, so the same store drains quickly once the core replays it. Stores whose address is marked poisoned are neither kept nor prefetched. When the core leaves run-ahead mode, all speculative slots are released in one cycle. The architectural stores that were queued before run-ahead mode stay in place and keep their order. Speculative data can never reach the drain port.

Top module: `runahead_stbuf`

## Requirements
- R1: After reset the block is in normal mode, holds no entries, and drives drain_valid, pf_valid, ra_enter and ld_hit low.
- R2: In normal mode a store is accepted whenever a slot is free. Stores leave on the drain port in arrival order, one per cycle with drain_valid and drain_ready both high. While drain_ready is low, drain_valid, drain_addr and drain_data hold steady.
- R3: In normal mode, a store that finds every slot taken is not kept. In that same cycle ra_enter is high, and ra_active is high from the next cycle on. A high ra_req in normal mode enters run-ahead mode in the same way.
- R4: A load with ld_valid high gets ld_hit high and the data of a matching queued store in the same cycle. Architectural and speculative entries both take part. A match compares the full address.
- R5: If several queued stores share the load's address, the data of the youngest one is returned.
- R6: In run-ahead mode, a store that arrives when every slot is taken is dropped. A later load to its address sees no hit unless an older store matches. Occupancy never exceeds DEPTH.
- R7: Every run-ahead store with st_poison low, kept or dropped, gives pf_valid high for exactly the next cycle. pf_line then equals st_addr shifted right by LINE_BITS.
- R8: A run-ahead store with st_poison high is not buffered and produces no prefetch request.
- R9: Speculative entries never appear on the drain port. Once the architectural entries are gone, drain_valid stays low even when speculative entries remain.
- R10: A cycle with ra_exit high in run-ahead mode releases every speculative entry at once and returns to normal mode on the next cycle. Queued architectural entries keep their order and drain afterwards.
- R11: A load with no matching entry returns ld_hit low and ld_data zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store present this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_poison | input | 1 | Store address depends on missing data (run-ahead only) |
| ld_valid | input | 1 | Load lookup present |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | Lookup matched a queued store |
| ld_data | output | DW | Forwarded data of the youngest match |
| drain_valid | output | 1 | Oldest architectural store offered to memory |
| drain_ready | input | 1 | Memory accepts the offered store |
| drain_addr | output | AW | Address of the offered store |
| drain_data | output | DW | Data of the offered store |
| pf_valid | output | 1 | Prefetch request valid |
| pf_line | output | AW-LINE_BITS | Cache-line address to prefetch |
| ra_req | input | 1 | Core asks to enter run-ahead mode |
| ra_exit | input | 1 | Core leaves run-ahead mode |
| ra_active | output | 1 | Run-ahead mode is in force |
| ra_enter | output | 1 | Entry condition seen this cycle |

## Verification
The checker takes for granted that st_poison is only raised while ra_active is high. It also assumes that ra_exit is raised only in run-ahead mode, and never in a cycle that carries a store. The mode exit is therefore the only event that shrinks the speculative count. The stimulus holds every input low outside the task that drives it. It raises poison only on run-ahead stores and pulses the exit input alone. drain_ready is moved freely, both with and without architectural entries queued.

// File: rtl/rab_pkg.sv
// Shared types for the run-ahead store buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rab_pkg;

    // Operating mode of the buffer
    typedef enum logic [0:0] {
        MODE_NORMAL   = 1'b0,
        MODE_RUNAHEAD = 1'b1
    } rab_mode_e;

endpackage

// File: rtl/rab_mode_ctl.sv
// Mode controller: tracks normal versus run-ahead operation.
// Enters run-ahead on a core request or on a store that finds the queue
// full; leaves on the exit input. Assumes ra_exit is only meaningful
// while in run-ahead mode.
module rab_mode_ctl
    import rab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic st_valid,
    input  logic buf_full,
    input  logic ra_req,
    input  logic ra_exit,
    output logic ra_active,
    output logic ra_enter,
    output logic ra_leave
);

    rab_mode_e mode_q;
    rab_mode_e mode_d;

    // Entry and exit conditions for the current cycle
    always_comb begin
        ra_active = (mode_q == MODE_RUNAHEAD);
        ra_enter  = !ra_active && (ra_req || (st_valid && buf_full));
        ra_leave  = ra_active && ra_exit;
    end

    // Next-mode selection, exit takes priority
    always_comb begin
        mode_d = mode_q;
        if (ra_leave) begin
            mode_d = MODE_NORMAL;
        end else if (ra_enter) begin
            mode_d = MODE_RUNAHEAD;
        end
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/rab_entry_queue.sv
// Circular store queue. Architectural entries always sit at the old end,
// speculative entries at the young end, so releasing all speculative
// entries is a single counter clear. Assumes DEPTH is a power of two of
// at least 2, that pushes only happen when not full, that pop only
// happens when architectural entries exist, and that push_spec and
// flush_spec are never high together.
module rab_entry_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_arch,
    input  logic                         push_spec,
    input  logic                         flush_spec,
    input  logic                         pop,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    output logic [$clog2(DEPTH)-1:0]     head_ptr,
    output logic [$clog2(DEPTH+1)-1:0]   arch_cnt,
    output logic [$clog2(DEPTH+1)-1:0]   spec_cnt,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         full,
    output logic [DEPTH-1:0][AW-1:0]     ent_addr,
    output logic [DEPTH-1:0][DW-1:0]     ent_data
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] tail_ptr;
    logic          do_push;

    // Derived occupancy, full flag and write position
    always_comb begin
        occ      = arch_cnt + spec_cnt;
        full     = (occ == CW'(DEPTH));
        tail_ptr = head_ptr + occ[PW-1:0];
        do_push  = push_arch || push_spec;
    end

    // Entry storage, written at the tail on any accepted store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            ent_data <= '0;
        end else if (do_push) begin
            ent_addr[tail_ptr] <= wr_addr;
            ent_data[tail_ptr] <= wr_data;
        end
    end

    // Head pointer advances on each drained entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_ptr <= '0;
        end else if (pop) begin
            head_ptr <= head_ptr + PW'(1);
        end
    end

    // Architectural count: grows on normal stores, shrinks on drain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_cnt <= '0;
        end else begin
            arch_cnt <= arch_cnt + CW'(push_arch) - CW'(pop);
        end
    end

    // Speculative count: grows on run-ahead stores, cleared on exit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_cnt <= '0;
        end else if (flush_spec) begin
            spec_cnt <= '0;
        end else begin
            spec_cnt <= spec_cnt + CW'(push_spec);
        end
    end

endmodule

// File: rtl/rab_fwd_search.sv
// Load lookup: compares the load address with every live entry, walked
// from oldest to youngest, and returns the data of the youngest match.
// Assumes entries outside [head, head+occ) hold stale data to be ignored.
module rab_fwd_search #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                         ld_valid,
    input  logic [AW-1:0]                ld_addr,
    input  logic [$clog2(DEPTH)-1:0]     head_ptr,
    input  logic [$clog2(DEPTH+1)-1:0]   occ,
    input  logic [DEPTH-1:0][AW-1:0]     ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]     ent_data,
    output logic                         ld_hit,
    output logic [DW-1:0]                ld_data
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]         age_match;
    logic [DEPTH-1:0][DW-1:0] age_data;

    // One comparator per age position, age 0 being the oldest entry
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PW-1:0] slot;
        logic          live;
        // Map age to slot and qualify the match
        always_comb begin
            slot         = head_ptr + PW'(g);
            live         = (CW'(g) < occ);
            age_match[g] = ld_valid && live && (ent_addr[slot] == ld_addr);
            age_data[g]  = ent_data[slot];
        end
    end

    // Youngest match wins: later ages overwrite earlier ones
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_match[i]) begin
                ld_hit  = 1'b1;
                ld_data = age_data[i];
            end
        end
    end

endmodule

// File: rtl/rab_pf_gen.sv
// Prefetch request register: turns a qualified run-ahead store into a
// one-cycle cache-line request on the following cycle.
// Assumes the caller already removed poisoned stores from fire.
module rab_pf_gen #(
    parameter int AW        = 32,
    parameter int LINE_BITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire,
    input  logic [AW-1:0]         addr,
    output logic                  pf_valid,
    output logic [AW-LINE_BITS-1:0] pf_line
);

    // Capture the line address of each qualified store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_line  <= '0;
        end else begin
            pf_valid <= fire;
            if (fire) begin
                pf_line <= addr[AW-1:LINE_BITS];
            end
        end
    end

endmodule

// File: rtl/runahead_stbuf.sv
// Run-ahead store buffer top. Queues architectural stores and drains
// them in order; a store that meets a full queue in normal mode triggers
// run-ahead entry instead of a stall. In run-ahead mode speculative
// stores are kept while slots remain, forwarded to loads, prefetched by
// line, and released together on exit. Assumes st_poison only rises in
// run-ahead mode and no store accompanies ra_exit.
module runahead_stbuf #(
    parameter int DEPTH     = 8,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LINE_BITS = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic [AW-1:0]           st_addr,
    input  logic [DW-1:0]           st_data,
    input  logic                    st_poison,
    input  logic                    ld_valid,
    input  logic [AW-1:0]           ld_addr,
    output logic                    ld_hit,
    output logic [DW-1:0]           ld_data,
    output logic                    drain_valid,
    input  logic                    drain_ready,
    output logic [AW-1:0]           drain_addr,
    output logic [DW-1:0]           drain_data,
    output logic                    pf_valid,
    output logic [AW-LINE_BITS-1:0] pf_line,
    input  logic                    ra_req,
    input  logic                    ra_exit,
    output logic                    ra_active,
    output logic                    ra_enter
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic                     full;
    logic                     ra_leave;
    logic                     push_arch;
    logic                     push_spec;
    logic                     pop;
    logic                     pf_fire;
    logic [PW-1:0]            head_ptr;
    logic [CW-1:0]            arch_cnt;
    logic [CW-1:0]            spec_cnt;
    logic [CW-1:0]            occ;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;

    rab_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_valid  (st_valid),
        .buf_full  (full),
        .ra_req    (ra_req),
        .ra_exit   (ra_exit),
        .ra_active (ra_active),
        .ra_enter  (ra_enter),
        .ra_leave  (ra_leave)
    );

    // Store acceptance, drain handshake and prefetch qualification
    always_comb begin
        push_arch   = st_valid && !ra_active && !full;
        push_spec   = st_valid && ra_active && !ra_exit && !st_poison && !full;
        drain_valid = (arch_cnt != '0);
        pop         = drain_valid && drain_ready;
        pf_fire     = st_valid && ra_active && !st_poison;
        drain_addr  = ent_addr[head_ptr];
        drain_data  = ent_data[head_ptr];
    end

    rab_entry_queue #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_arch  (push_arch),
        .push_spec  (push_spec),
        .flush_spec (ra_leave),
        .pop        (pop),
        .wr_addr    (st_addr),
        .wr_data    (st_data),
        .head_ptr   (head_ptr),
        .arch_cnt   (arch_cnt),
        .spec_cnt   (spec_cnt),
        .occ        (occ),
        .full       (full),
        .ent_addr   (ent_addr),
        .ent_data   (ent_data)
    );

    rab_fwd_search #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_fwd (
        .ld_valid (ld_valid),
        .ld_addr  (ld_addr),
        .head_ptr (head_ptr),
        .occ      (occ),
        .ent_addr (ent_addr),
        .ent_data (ent_data),
        .ld_hit   (ld_hit),
        .ld_data  (ld_data)
    );

    rab_pf_gen #(
        .AW        (AW),
        .LINE_BITS (LINE_BITS)
    ) u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (pf_fire),
        .addr     (st_addr),
        .pf_valid (pf_valid),
        .pf_line  (pf_line)
    );

endmodule

// File: rtl/runahead_stbuf_chk.sv
// Property checker for the run-ahead store buffer, bound into the top.
// Assumes the input rules listed in the brief.
module runahead_stbuf_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         st_valid,
    input logic                         st_poison,
    input logic                         ld_valid,
    input logic                         ld_hit,
    input logic                         drain_valid,
    input logic                         drain_ready,
    input logic [AW-1:0]                drain_addr,
    input logic [DW-1:0]                drain_data,
    input logic                         pf_valid,
    input logic                         ra_active,
    input logic                         ra_exit,
    input logic [$clog2(DEPTH+1)-1:0]   occ,
    input logic [$clog2(DEPTH+1)-1:0]   spec_cnt
);

    localparam int CW = $clog2(DEPTH + 1);

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_addr) && $stable(drain_data))); // R2

    AST_FULL_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_active && st_valid && occ == CW'(DEPTH)) |=> ra_active); // R3

    AST_HIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> (ld_valid && occ != '0)); // R4

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R6

    AST_PF_IN_RUNAHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ra_active)); // R7

    AST_NO_POISON_PF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_valid) && $past(st_poison)) |-> !pf_valid); // R8

    AST_NORMAL_NO_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
        !ra_active |-> (spec_cnt == '0)); // R9

    AST_EXIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_active && ra_exit) |=> (!ra_active && spec_cnt == '0)); // R10

endmodule

bind runahead_stbuf runahead_stbuf_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_valid    (st_valid),
    .st_poison   (st_poison),
    .ld_valid    (ld_valid),
    .ld_hit      (ld_hit),
    .drain_valid (drain_valid),
    .drain_ready (drain_ready),
    .drain_addr  (drain_addr),
    .drain_data  (drain_data),
    .pf_valid    (pf_valid),
    .ra_active   (ra_active),
    .ra_exit     (ra_exit),
    .occ         (occ),
    .spec_cnt    (spec_cnt)
);

// File: tb/runahead_stbuf_bench.sv
// Scoreboard bench: store tasks push expected drains and prefetches into
// queues; a monitor pops and compares them as the design produces them.
module runahead_stbuf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int AW         = 32;
    localparam int DW         = 32;
    localparam int LINE_BITS  = 6;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    st_valid = 1'b0;
    logic [AW-1:0]           st_addr = '0;
    logic [DW-1:0]           st_data = '0;
    logic                    st_poison = 1'b0;
    logic                    ld_valid = 1'b0;
    logic [AW-1:0]           ld_addr = '0;
    logic                    ld_hit;
    logic [DW-1:0]           ld_data;
    logic                    drain_valid;
    logic                    drain_ready = 1'b0;
    logic [AW-1:0]           drain_addr;
    logic [DW-1:0]           drain_data;
    logic                    pf_valid;
    logic [AW-LINE_BITS-1:0] pf_line;
    logic                    ra_req = 1'b0;
    logic                    ra_exit = 1'b0;
    logic                    ra_active;
    logic                    ra_enter;

    int n_chk  = 0;
    int n_fail = 0;

    logic [AW+DW-1:0]        exp_drain[$];
    logic [AW-LINE_BITS-1:0] exp_pf[$];

    runahead_stbuf #(
        .DEPTH     (DEPTH),
        .AW        (AW),
        .DW        (DW),
        .LINE_BITS (LINE_BITS)
    ) u_runahead_stbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_data     (st_data),
        .st_poison   (st_poison),
        .ld_valid    (ld_valid),
        .ld_addr     (ld_addr),
        .ld_hit      (ld_hit),
        .ld_data     (ld_data),
        .drain_valid (drain_valid),
        .drain_ready (drain_ready),
        .drain_addr  (drain_addr),
        .drain_data  (drain_data),
        .pf_valid    (pf_valid),
        .pf_line     (pf_line),
        .ra_req      (ra_req),
        .ra_exit     (ra_exit),
        .ra_active   (ra_active),
        .ra_enter    (ra_enter)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Drive one store for one cycle and record what it should produce
    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit poison, input bit exp_arch, input bit exp_prefetch);
        @(negedge clk);
        st_valid  = 1'b1;
        st_addr   = a;
        st_data   = d;
        st_poison = poison;
        if (exp_arch)     exp_drain.push_back({a, d});
        if (exp_prefetch) exp_pf.push_back(a[AW-1:LINE_BITS]);
        @(negedge clk);
        st_valid  = 1'b0;
        st_poison = 1'b0;
    endtask

    // Combinational lookup checked shortly after the inputs change
    task automatic do_load(input logic [AW-1:0] a, input bit hit, input logic [DW-1:0] d, input string req);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr  = a;
        #1;
        check(ld_hit == hit, req, 64'(ld_hit), 64'(hit));
        check(ld_data == d, req, 64'(ld_data), 64'(d));
        ld_valid = 1'b0;
    endtask

    task automatic ready_for(input int cycles);
        @(negedge clk);
        drain_ready = 1'b1;
        repeat (cycles) @(negedge clk);
        drain_ready = 1'b0;
    endtask

    // Monitor: samples one time unit before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            if (rst_n) begin
                if (drain_valid && drain_ready) begin
                    if (exp_drain.size() == 0) begin
                        check(1'b0, "R9 unexpected drain", 64'(drain_addr), 64'h0);
                    end else begin
                        logic [AW+DW-1:0] e;
                        e = exp_drain.pop_front();
                        check({drain_addr, drain_data} == e, "R2 drain order", {drain_addr, drain_data}, e);
                    end
                end
                if (pf_valid) begin
                    if (exp_pf.size() == 0) begin
                        check(1'b0, "R8 unexpected prefetch", 64'(pf_line), 64'h0);
                    end else begin
                        logic [AW-LINE_BITS-1:0] p;
                        p = exp_pf.pop_front();
                        check(pf_line == p, "R7 prefetch line", 64'(pf_line), 64'(p));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(!ra_active && !drain_valid && !pf_valid && !ra_enter, "R1 reset state",
              {60'h0, ra_active, drain_valid, pf_valid, ra_enter}, 64'h0);
        do_load(32'h100, 1'b0, '0, "R1 empty lookup");

        // R2 normal queueing with drain held off
        do_store(32'h100, 32'hA0, 1'b0, 1'b1, 1'b0);
        do_store(32'h140, 32'hA1, 1'b0, 1'b1, 1'b0);
        do_store(32'h180, 32'hA2, 1'b0, 1'b1, 1'b0);
        do_load(32'h140, 1'b1, 32'hA1, "R4 normal forward");
        do_store(32'h1C0, 32'hA3, 1'b0, 1'b1, 1'b0);
        check(drain_valid && drain_addr == 32'h100, "R2 oldest offered", 64'(drain_addr), 64'h100);

        // R3 store into a full queue triggers run-ahead
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = 32'h200;
        st_data  = 32'hBAD;
        #1;
        check(ra_enter == 1'b1, "R3 enter pulse", 64'(ra_enter), 64'h1);
        @(negedge clk);
        st_valid = 1'b0;
        check(ra_active == 1'b1, "R3 mode entered", 64'(ra_active), 64'h1);
        do_load(32'h200, 1'b0, '0, "R3 trigger store not kept");

        // Drain two architectural entries to make room
        ready_for(2);

        // R4/R5/R7/R8 speculative stores
        do_store(32'h1000, 32'hD1, 1'b0, 1'b0, 1'b1);
        do_load(32'h1000, 1'b1, 32'hD1, "R4 speculative forward");
        do_store(32'h2000, 32'hEE, 1'b1, 1'b0, 1'b0);
        do_load(32'h2000, 1'b0, '0, "R8 poisoned not buffered");
        do_store(32'h1000, 32'hD2, 1'b0, 1'b0, 1'b1);
        do_load(32'h1000, 1'b1, 32'hD2, "R5 youngest wins");

        // R6 overflow store dropped but prefetched
        do_store(32'h3000, 32'hF0, 1'b0, 1'b0, 1'b1);
        do_load(32'h3000, 1'b0, '0, "R6 overflow dropped");
        do_load(32'h1C0, 1'b1, 32'hA3, "R4 architectural forward in run-ahead");

        // R10 exit releases speculative entries
        @(negedge clk);
        ra_exit = 1'b1;
        @(negedge clk);
        ra_exit = 1'b0;
        check(ra_active == 1'b0, "R10 back to normal", 64'(ra_active), 64'h0);
        do_load(32'h1000, 1'b0, '0, "R10 speculative released");
        do_load(32'h1C0, 1'b1, 32'hA3, "R10 architectural kept");
        check(drain_valid && drain_addr == 32'h180, "R10 order kept", 64'(drain_addr), 64'h180);
        ready_for(3);
        check(drain_valid == 1'b0, "R9 queue empty after drain", 64'(drain_valid), 64'h0);

        // R3 entry on request, R9 speculative never drains
        @(negedge clk);
        ra_req = 1'b1;
        #1;
        check(ra_enter == 1'b1, "R3 request pulse", 64'(ra_enter), 64'h1);
        @(negedge clk);
        ra_req = 1'b0;
        check(ra_active == 1'b1, "R3 request entered", 64'(ra_active), 64'h1);
        do_store(32'h4000, 32'hC4, 1'b0, 1'b0, 1'b1);
        ready_for(2);
        check(drain_valid == 1'b0, "R9 speculative not drained", 64'(drain_valid), 64'h0);
        do_load(32'h4000, 1'b1, 32'hC4, "R4 forward after request entry");
        @(negedge clk);
        ra_exit = 1'b1;
        @(negedge clk);
        ra_exit = 1'b0;
        check(!ra_active && !drain_valid, "R10 exit with only speculative",
              {62'h0, ra_active, drain_valid}, 64'h0);

        // R11 miss and R2 wrap-around reuse
        do_load(32'h5555_0000, 1'b0, '0, "R11 no match");
        do_store(32'h600, 32'h66, 1'b0, 1'b1, 1'b0);
        ready_for(2);

        repeat (3) @(negedge clk);
        check(exp_drain.size() == 0, "R2 all drains seen", 64'(exp_drain.size()), 64'h0);
        check(exp_pf.size() == 0, "R7 all prefetches seen", 64'(exp_pf.size()), 64'h0);
        summary();
        $finish;
    end

endmodule